// File: doc/BRIEF.md
# Byte Program Pulse Sequencer

This block writes a list of bytes into a flash array by itself, with no processor involved. Each list entry is an address and a data byte. For each entry the block raises the latch enable and issues a single write strobe that carries the address and the data. It then fires high-voltage pulses of fixed length. After each pulse it waits a fixed recovery time and reads the cell back.

While the byte does not yet read back correctly, the block counts pulses. Once the byte verifies, the block fires the same number of pulses again as extra margin. It then reads the cell one last time before moving on to the next entry.

A start strobe launches the run, but only if the programming-voltage status input is high at that moment. The list is fetched through an index output, with address and data returned combinationally. An entry whose data is zero ends the list. The block reports completion with a one-cycle `done` pulse. Any failure raises `error`, which holds until reset. The pulse and recovery lengths are parameters given in clock cycles. At an 8 MHz clock they are 176 and 80 cycles (22 µs and 10 µs).

Top module: `byte_pulse_programmer`

## Requirements
- R1: While reset is held and right after it is released, `done`, `error`, `hv_en`, `latch_en` and `wr_en` are all low.
- R2: If `vpp_ok` is low when `start` is seen, `error` rises and no write strobe and no pulse is issued.
- R3: For each list entry the block issues exactly one one-cycle `wr_en` strobe, with `cell_addr`/`wr_data` equal to that entry. `latch_en` is high from the strobe through the last pulse of the entry, and `hv_en` is high only while `latch_en` is high.
- R4: Every pulse holds `hv_en` high for exactly PULSE_CYC cycles. At least RECOV_CYC low cycles follow each pulse before the next pulse or the read-back decision.
- R5: A byte that first reads back correctly after N pulses receives N more pulses, 2N in total, and the block then moves to the next entry.
- R6: If the read-back still mismatches after MAX_PULSES+1 pulses (51 by default), `error` rises and no further pulse is fired. A byte that first verifies on pulse MAX_PULSES+1 still completes, with 2·(MAX_PULSES+1) pulses.
- R7: If the read-back after the last margin pulse mismatches, `error` rises.
- R8: An entry whose data field is 0 ends the list. No write is issued for it or for any later entry, and `done` pulses high for exactly one cycle. A list that starts with such an entry gives `done` with no write.
- R9: Once `error` is high it stays high until reset. `done` is never raised, and `start` then causes no write and no pulse.
- R10: `latch_en` falls once after each byte that completes, so it drops between successive bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle run request, accepted when idle |
| vpp_ok | input | 1 | Programming voltage present status |
| item_idx | output | IDX_W | Index of the list entry being fetched |
| item_addr | input | ADDR_W | Address of entry `item_idx` |
| item_data | input | DATA_W | Data of entry `item_idx`; 0 ends the list |
| wr_en | output | 1 | One-cycle write strobe to the array latches |
| cell_addr | output | ADDR_W | Address for the write and for the read-back |
| wr_data | output | DATA_W | Data written with `wr_en` |
| rd_data | input | DATA_W | Array contents at `cell_addr` |
| latch_en | output | 1 | Address/data latch enable for program mode |
| hv_en | output | 1 | High-voltage pulse enable |
| done | output | 1 | One-cycle pulse: whole list programmed |
| error | output | 1 | Sticky failure flag |

## Verification
The bench's array model makes each cell take a chosen number of pulses before it reads correctly, and some cells can be told to flip back after a given pulse. Lists of cells needing 1, 3 and 7 pulses show whether the margin phase matches the first phase pulse for pulse. Cells needing 51 and 52 pulses sit on either side of the pulse limit and expose an off-by-one in the limit compare. A cell that decays during its margin phase separates the final read-back from the first verify. An empty list, a list with entries after the delimiter, and a start with the voltage absent show that the run ends in the right place and touches nothing else.

// File: rtl/pps_pkg.sv
package pps_pkg;
  typedef enum logic [2:0] {
    PS_IDLE,
    PS_FETCH,
    PS_HVON,
    PS_PULSE,
    PS_RECOV,
    PS_CHECK,
    PS_ERROR
  } pps_state_e;
endpackage

// File: rtl/pps_delay.sv
module pps_delay #(
  parameter int TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  output logic             expired
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)               cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/pps_tally.sv
module pps_tally #(
  parameter int MAX_PULSES = 50,
  parameter int CNT_W      = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  input  logic dec,
  input  logic mark,
  output logic margin,
  output logic at_limit,
  output logic at_one
);
  logic [CNT_W-1:0] cnt_q;
  logic             margin_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      margin_q <= 1'b0;
    end else begin
      if (inc)      cnt_q <= cnt_q + 1'b1;
      else if (dec) cnt_q <= cnt_q - 1'b1;
      if (mark)     margin_q <= 1'b1;
    end
  end

  assign margin   = margin_q;
  // count before this increment already at the limit -> after it, limit exceeded
  assign at_limit = (cnt_q >= CNT_W'(MAX_PULSES));
  // count before this decrement is one -> after it, zero
  assign at_one   = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/byte_pulse_programmer.sv
module byte_pulse_programmer
  import pps_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 8,
  parameter int PULSE_CYC  = 176,
  parameter int RECOV_CYC  = 80,
  parameter int MAX_PULSES = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              vpp_ok,
  output logic [IDX_W-1:0]  item_idx,
  input  logic [ADDR_W-1:0] item_addr,
  input  logic [DATA_W-1:0] item_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] cell_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] rd_data,
  output logic              latch_en,
  output logic              hv_en,
  output logic              done,
  output logic              error
);
  localparam int LONGEST = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
  localparam int TMR_W   = $clog2(LONGEST + 1);
  localparam int CNT_W   = $clog2(MAX_PULSES + 2);
  localparam logic [TMR_W-1:0] PULSE_LD = TMR_W'(PULSE_CYC - 1);
  localparam logic [TMR_W-1:0] RECOV_LD = TMR_W'(RECOV_CYC - 1);

  pps_state_e state_q, state_d;

  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic wr_q, latch_q, hv_q, done_q, err_q;

  logic             tmr_load, tmr_expired;
  logic [TMR_W-1:0] tmr_val;
  logic t_clr, t_inc, t_dec, t_mark;
  logic margin, at_limit, at_one;
  logic go_start, go_byte, go_next, go_done, go_err, hv_on, hv_off;
  logic verified;

  assign verified = (rd_data == data_q);

  pps_delay #(.TMR_W(TMR_W)) u_delay (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_expired)
  );

  pps_tally #(.MAX_PULSES(MAX_PULSES), .CNT_W(CNT_W)) u_tally (
    .clk     (clk),
    .rst     (rst),
    .clr     (t_clr),
    .inc     (t_inc),
    .dec     (t_dec),
    .mark    (t_mark),
    .margin  (margin),
    .at_limit(at_limit),
    .at_one  (at_one)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    t_clr    = 1'b0;
    t_inc    = 1'b0;
    t_dec    = 1'b0;
    t_mark   = 1'b0;
    go_start = 1'b0;
    go_byte  = 1'b0;
    go_next  = 1'b0;
    go_done  = 1'b0;
    go_err   = 1'b0;
    hv_on    = 1'b0;
    hv_off   = 1'b0;
    case (state_q)
      PS_IDLE: begin
        if (start) begin
          go_start = 1'b1;
          if (vpp_ok) state_d = PS_FETCH;
          else begin
            state_d = PS_ERROR;
            go_err  = 1'b1;
          end
        end
      end
      PS_FETCH: begin
        if (item_data == '0) begin
          state_d = PS_IDLE;
          go_done = 1'b1;
        end else begin
          state_d = PS_HVON;
          go_byte = 1'b1;
          t_clr   = 1'b1;
        end
      end
      PS_HVON: begin
        state_d  = PS_PULSE;
        hv_on    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = PULSE_LD;
      end
      PS_PULSE: begin
        if (tmr_expired) begin
          state_d  = PS_RECOV;
          hv_off   = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = RECOV_LD;
        end
      end
      PS_RECOV: begin
        if (tmr_expired) state_d = PS_CHECK;
      end
      PS_CHECK: begin
        if (!margin) begin
          t_inc = 1'b1;
          if (verified) begin
            t_mark  = 1'b1;
            state_d = PS_HVON;
          end else if (at_limit) begin
            state_d = PS_ERROR;
            go_err  = 1'b1;
          end else begin
            state_d = PS_HVON;
          end
        end else begin
          t_dec = 1'b1;
          if (!at_one) begin
            state_d = PS_HVON;
          end else if (verified) begin
            state_d = PS_FETCH;
            go_next = 1'b1;
          end else begin
            state_d = PS_ERROR;
            go_err  = 1'b1;
          end
        end
      end
      PS_ERROR: state_d = PS_ERROR;
      default:  state_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= PS_IDLE;
      idx_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wr_q    <= 1'b0;
      latch_q <= 1'b0;
      hv_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wr_q    <= go_byte;
      done_q  <= go_done;
      if (go_start) idx_q <= '0;
      if (go_next)  idx_q <= idx_q + 1'b1;
      if (go_byte) begin
        addr_q  <= item_addr;
        data_q  <= item_data;
        latch_q <= 1'b1;
      end
      if (go_next || go_err) latch_q <= 1'b0;
      if (hv_on)  hv_q <= 1'b1;
      if (hv_off) hv_q <= 1'b0;
      if (go_err) err_q <= 1'b1;
    end
  end

  assign item_idx  = idx_q;
  assign wr_en     = wr_q;
  assign cell_addr = addr_q;
  assign wr_data   = data_q;
  assign latch_en  = latch_q;
  assign hv_en     = hv_q;
  assign done      = done_q;
  assign error     = err_q;
endmodule

// File: rtl/byte_pulse_programmer_chk.sv
module byte_pulse_programmer_chk (
  input logic clk,
  input logic rst,
  input logic wr_en,
  input logic latch_en,
  input logic hv_en,
  input logic done,
  input logic error
);
  AST_HV_UNDER_LATCH: assert property (@(posedge clk) disable iff (rst) hv_en |-> latch_en);              // R3
  AST_WR_NOT_HV:      assert property (@(posedge clk) disable iff (rst) wr_en |-> !hv_en);                // R3
  AST_WR_THEN_HV:     assert property (@(posedge clk) disable iff (rst) wr_en |=> hv_en);                 // R3
  AST_HV_RECOVERS:    assert property (@(posedge clk) disable iff (rst) $fell(hv_en) |=> !hv_en);         // R4
  AST_DONE_SINGLE:    assert property (@(posedge clk) disable iff (rst) done |=> !done);                  // R8
  AST_ERR_STICKY:     assert property (@(posedge clk) disable iff (rst) error |=> error);                 // R9
  AST_ERR_NO_DONE:    assert property (@(posedge clk) disable iff (rst) error |-> !done);                 // R9
  AST_ERR_QUIET:      assert property (@(posedge clk) disable iff (rst) error |-> (!hv_en && !wr_en));    // R9
endmodule

bind byte_pulse_programmer byte_pulse_programmer_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .latch_en(latch_en),
  .hv_en   (hv_en),
  .done    (done),
  .error   (error)
);

// File: tb/byte_pulse_programmer_tb.sv
`timescale 1ns/1ps
module byte_pulse_programmer_tb;
  localparam int AW = 8, DW = 8, IW = 3, PC = 6, RC = 4, MP = 50;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0, vpp_ok = 1'b1;
  logic [IW-1:0] item_idx;
  logic [AW-1:0] item_addr, cell_addr;
  logic [DW-1:0] item_data, wr_data, rd_data;
  logic wr_en, latch_en, hv_en, done, error;

  always #2.5 clk = ~clk;

  logic [AW-1:0] la [8];
  logic [DW-1:0] ld [8];
  int need_of [256];
  int brk_of  [256];
  int hits    [256];
  logic [DW-1:0] mem [256];

  assign item_addr = la[item_idx];
  assign item_data = ld[item_idx];
  assign rd_data   = mem[cell_addr];

  byte_pulse_programmer #(
    .ADDR_W(AW), .DATA_W(DW), .IDX_W(IW),
    .PULSE_CYC(PC), .RECOV_CYC(RC), .MAX_PULSES(MP)
  ) u_dut (
    .clk(clk), .rst(rst), .start(start), .vpp_ok(vpp_ok),
    .item_idx(item_idx), .item_addr(item_addr), .item_data(item_data),
    .wr_en(wr_en), .cell_addr(cell_addr), .wr_data(wr_data), .rd_data(rd_data),
    .latch_en(latch_en), .hv_en(hv_en), .done(done), .error(error)
  );

  int checks = 0, failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural observer / array model
  int pulses[$];
  int exp_p[$];
  logic [AW-1:0] wa[$];
  logic [DW-1:0] wdq[$];
  logic [AW-1:0] tgt;
  logic [DW-1:0] tdat;
  bit prev_hv, prev_latch, gap_valid, seen_done;
  int hi_len, lo_len, done_cnt, latch_falls;
  bit exp_err;
  int exp_nwr;

  always @(negedge clk) begin
    if (rst) begin
      prev_hv = 0; prev_latch = 0; gap_valid = 0; hi_len = 0; lo_len = 0;
    end else begin
      if (wr_en) begin
        tgt = cell_addr; tdat = wr_data;
        wa.push_back(cell_addr); wdq.push_back(wr_data); pulses.push_back(0);
        gap_valid = 0;
      end
      if (hv_en && !prev_hv) begin
        if (pulses.size() > 0) begin
          pulses[pulses.size()-1]++;
          if (pulses.size() <= exp_p.size())
            chk(pulses[pulses.size()-1] <= exp_p[pulses.size()-1], "R5 R6 pulse count bound",
                pulses[pulses.size()-1], exp_p[pulses.size()-1]);
        end
        hits[tgt]++;
        if (hits[tgt] >= need_of[tgt]) mem[tgt] = tdat;
        if (brk_of[tgt] != 0 && hits[tgt] >= brk_of[tgt]) mem[tgt] = ~tdat;
        if (gap_valid) chk(lo_len >= RC, "R4 recovery gap", lo_len, RC);
        hi_len = 0;
      end
      if (!hv_en && prev_hv) begin
        chk(hi_len == PC, "R4 pulse width", hi_len, PC);
        lo_len = 0; gap_valid = 1;
      end
      if (hv_en) hi_len++; else lo_len++;
      if (!latch_en && prev_latch) latch_falls++;
      if (done) begin seen_done = 1; done_cnt++; end
      if (done && error) chk(0, "R9 done with error", 1, 0);
      prev_hv = hv_en; prev_latch = latch_en;
    end
  end

  task automatic do_reset();
    rst = 1;
    for (int a = 0; a < 256; a++) begin
      need_of[a] = 1; brk_of[a] = 0; hits[a] = 0; mem[a] = '1;
    end
    for (int i = 0; i < 8; i++) begin la[i] = '0; ld[i] = '0; end
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic set_item(input int i, input int a, input int d, input int n, input int b);
    la[i] = AW'(a); ld[i] = DW'(d); need_of[a] = n; brk_of[a] = b;
  endtask

  task automatic build_model();
    exp_p.delete(); exp_err = 0; exp_nwr = 0;
    for (int i = 0; i < 8; i++) begin
      int n;
      if (ld[i] == 0) break;
      exp_nwr++;
      n = need_of[la[i]];
      if (n > MP + 1) begin exp_p.push_back(MP + 1); exp_err = 1; break; end
      if (brk_of[la[i]] != 0 && brk_of[la[i]] <= 2 * n) begin
        exp_p.push_back(2 * n); exp_err = 1; break;
      end
      exp_p.push_back(2 * n);
    end
  endtask

  task automatic run_list();
    pulses.delete(); wa.delete(); wdq.delete();
    seen_done = 0; done_cnt = 0; latch_falls = 0;
    build_model();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    for (int k = 0; k < 20000 && !seen_done && !error; k++) begin
      @(negedge clk); #1;
    end
    repeat (2) @(negedge clk);
    #1;
  endtask

  task automatic verify_run(input string req);
    chk(error == exp_err, {req, " error flag"}, error, exp_err);
    chk(done_cnt == (exp_err ? 0 : 1), {req, " R8 done pulses"}, done_cnt, exp_err ? 0 : 1);
    chk(wa.size() == exp_nwr, {req, " R3 write count"}, wa.size(), exp_nwr);
    for (int i = 0; i < wa.size() && i < exp_nwr; i++) begin
      chk(pulses[i] == exp_p[i], {req, " pulses per byte"}, pulses[i], exp_p[i]);
      chk(wa[i] == la[i], {req, " R3 write address"}, wa[i], la[i]);
      chk(wdq[i] == ld[i], {req, " R3 write data"}, wdq[i], ld[i]);
    end
    if (!exp_err) chk(latch_falls == exp_nwr, {req, " R10 latch drops"}, latch_falls, exp_nwr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int wsz, psz;
    // R1 reset state
    rst = 1;
    repeat (2) @(negedge clk);
    #1;
    chk(!done && !error && !hv_en && !latch_en && !wr_en, "R1 outputs during reset",
        {done, error, hv_en, latch_en, wr_en}, 0);
    do_reset();
    #1;
    chk(!done && !error && !hv_en && !latch_en && !wr_en, "R1 outputs after reset",
        {done, error, hv_en, latch_en, wr_en}, 0);

    // R2 voltage absent
    set_item(0, 8'h10, 8'hA5, 1, 0);
    vpp_ok = 0;
    pulses.delete(); wa.delete(); wdq.delete(); seen_done = 0; done_cnt = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (5) @(negedge clk);
    #1;
    chk(error == 1, "R2 error without voltage", error, 1);
    chk(wa.size() == 0, "R2 no write without voltage", wa.size(), 0);
    chk(hits[8'h10] == 0, "R2 no pulse without voltage", hits[8'h10], 0);
    chk(done_cnt == 0, "R2 no done without voltage", done_cnt, 0);
    vpp_ok = 1;

    // R5 R8 R10 three bytes, delimiter, trailing entry
    do_reset();
    set_item(0, 8'h10, 8'hA5, 1, 0);
    set_item(1, 8'h11, 8'h3C, 3, 0);
    set_item(2, 8'h12, 8'h81, 7, 0);
    set_item(3, 8'h00, 8'h00, 1, 0);
    set_item(4, 8'h13, 8'h55, 1, 0);
    run_list();
    verify_run("R5 normal list");
    chk(mem[8'h13] == 8'hFF, "R8 entry after delimiter untouched", mem[8'h13], 8'hFF);
    chk(mem[8'h12] == 8'h81, "R5 last byte programmed", mem[8'h12], 8'h81);

    // R8 empty list
    set_item(0, 8'h40, 8'h00, 1, 0);
    run_list();
    verify_run("R8 empty list");

    // R6 limit boundary: 51 completes, 52 fails
    do_reset();
    set_item(0, 8'h20, 8'h77, MP + 1, 0);
    set_item(1, 8'h21, 8'h66, MP + 2, 0);
    set_item(2, 8'h22, 8'h44, 1, 0);
    run_list();
    verify_run("R6 pulse limit");

    // R9 sticky error, start ignored
    wsz = wa.size(); psz = hits[8'h21];
    repeat (20) @(negedge clk);
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    repeat (20) @(negedge clk);
    #1;
    chk(error == 1, "R9 error held", error, 1);
    chk(done_cnt == 0, "R9 no done after error", done_cnt, 0);
    chk(wa.size() == wsz, "R9 no write after error", wa.size(), wsz);
    chk(hits[8'h21] == psz, "R9 no pulse after error", hits[8'h21], psz);

    // R7 cell decays during margin phase
    do_reset();
    set_item(0, 8'h30, 8'h99, 4, 5);
    set_item(1, 8'h31, 8'h12, 1, 0);
    run_list();
    verify_run("R7 final verify");

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule